// File: doc/BRIEF.md
# DC-Link Voltage Monitor With Chopper

This block watches the DC-link bus of a motor drive. A one-bit sigma-delta stream that encodes the link voltage enters on `sd_bit`, qualified by `sd_valid`. A third-order sinc filter decimates the stream by 64 or by 128, as one control bit selects. Each decimated sample passes through a programmable offset. The corrected reading is then compared against three independent levels. The first is a trip level that shuts the system down on overvoltage. The second is a chopper level that switches on the brake chopper gate. The third is a low level that flags undervoltage.

Software programs the levels, the offset and the decimation ratio through a small 32-bit register port. Writes take effect on the next clock. Reads are combinational from the address. The corrected reading and the three flags can be read back through the same port, and they also drive dedicated output pins. The decimator has two named states. In `DEC_SETTLE` it discards the first three filter outputs after reset or after a ratio change. It moves to `DEC_LIVE` on the third discarded output, and it returns from `DEC_LIVE` to `DEC_SETTLE` when the ratio changes. The evaluator has three named states. `EV_WAIT` moves to `EV_CORRECT` when a live sample arrives. `EV_CORRECT` moves to `EV_DECIDE` unconditionally, and `EV_DECIDE` returns to `EV_WAIT` unconditionally.

Register map (byte offsets):
- 0x00 control: bit 0 selects the ratio (0 → 64, 1 → 128).
- 0x04 offset, 16 bits.
- 0x08 trip level.
- 0x0C chopper level.
- 0x10 low level.
- 0x14 reading, read-only.
- 0x18 flags, read-only.
- 0x1C, 0x20, 0x24 spare, 16 bits each.

Top module: `dclink_monitor`

## Requirements
- R1: Control bit 0 at 0x00 selects a decimation ratio of 64 (value 0) or 128 (value 1). A change of this bit flushes the filter and restarts settling.
- R2: For a stream with k ones in every 64 consecutive bits, the steady-state filtered value is 1024·k at either ratio, capped at 65535.
- R3: The corrected reading equals filtered + offset − 16384, where offset is the 16-bit value at 0x04. The result saturates to the range 0..65535.
- R4: The overvoltage pin `ov_o` and flag bit 0 at 0x18 are 1 exactly when the reading is strictly above the trip level at 0x08.
- R5: The chopper pin `chop_o` and flag bit 2 at 0x18 are 1 exactly when the reading is strictly above the chopper level at 0x0C.
- R6: The undervoltage pin `uv_o` and flag bit 1 at 0x18 are 1 exactly when the reading is strictly below the low level at 0x10.
- R7: The reading and the flags change only once per live decimated sample. The first three filter outputs after reset or after a ratio change are discarded, and the outputs hold meanwhile.
- R8: The 16-bit corrected reading reads back at 0x14.
- R9: The spare registers at 0x1C, 0x20 and 0x24 store and return 16 bits with no effect on the outputs. Writes to 0x14 and 0x18 are ignored. Unmapped addresses and reserved bits read as 0.
- R10: After reset, all registers, the reading, the flags and the three pins are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the modulator stream and the register port |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_valid | input | 1 | Qualifies one modulator bit |
| sd_bit | input | 1 | Sigma-delta modulator bit |
| reg_addr | input | 6 | Byte address of the register port |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ov_o | output | 1 | Overvoltage shutdown output |
| uv_o | output | 1 | Undervoltage output |
| chop_o | output | 1 | Brake chopper gate |

## Verification
The bench builds the block with its default parameters: ratios of 2^6 and 2^7, 16-bit values and three discarded outputs. At these settings a stream with k ones per 64 bits filters to exactly 1024·k at either ratio. This makes expected readings exact for any random duty, offset and level. Both saturation ends can be reached within a few hundred cycles, and so can the strict equality edges of every comparator and the settle window after reset.

// File: rtl/dclink_pkg.sv
package dclink_pkg;

    typedef enum logic [0:0] {
        DEC_SETTLE = 1'b0,
        DEC_LIVE   = 1'b1
    } dec_state_t;

    typedef enum logic [1:0] {
        EV_WAIT    = 2'd0,
        EV_CORRECT = 2'd1,
        EV_DECIDE  = 2'd2
    } ev_state_t;

    localparam logic [5:0] A_CTRL    = 6'h00;
    localparam logic [5:0] A_OFFSET  = 6'h04;
    localparam logic [5:0] A_TRIP    = 6'h08;
    localparam logic [5:0] A_CHOP    = 6'h0C;
    localparam logic [5:0] A_LOW     = 6'h10;
    localparam logic [5:0] A_READING = 6'h14;
    localparam logic [5:0] A_FLAGS   = 6'h18;
    localparam logic [5:0] A_SPARE0  = 6'h1C;
    localparam logic [5:0] A_SPARE1  = 6'h20;
    localparam logic [5:0] A_SPARE2  = 6'h24;

endpackage

// File: rtl/dclink_sinc3.sv
module dclink_sinc3
    import dclink_pkg::*;
#(
    parameter int LOG_R_LO = 6,
    parameter int LOG_R_HI = 7,
    parameter int OUT_W    = 16,
    parameter int SETTLE_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sd_valid,
    input  logic             sd_bit,
    input  logic             ratio_sel,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data,
    output logic             strobe_o,
    output logic             flush_o,
    output logic             ratio_o,
    output dec_state_t       state_o
);

    localparam int ACC_W = 3 * LOG_R_HI + 1;
    localparam int SH_LO = 3 * LOG_R_LO - OUT_W;
    localparam int SH_HI = 3 * LOG_R_HI - OUT_W;
    localparam int CNT_W = LOG_R_HI;
    localparam int SC_W  = $clog2(SETTLE_N + 1);
    localparam logic [ACC_W-1:0] OUT_MAX = ACC_W'((64'd1 << OUT_W) - 1);
    localparam logic [CNT_W-1:0] LAST_LO = CNT_W'((64'd1 << LOG_R_LO) - 1);
    localparam logic [CNT_W-1:0] LAST_HI = CNT_W'((64'd1 << LOG_R_HI) - 1);

    logic             ratio_q;
    logic             flush;
    logic             last;
    logic             strobe;
    logic [CNT_W-1:0] cnt_q;
    logic [SC_W-1:0]  settle_q;
    dec_state_t       state_q, state_d;

    assign flush  = (ratio_sel != ratio_q);
    assign last   = ratio_q ? (cnt_q == LAST_HI) : (cnt_q == LAST_LO);
    assign strobe = sd_valid && last && !flush;

    // integrator chain at the modulator rate
    for (genvar g = 0; g < 3; g++) begin : g_int
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] addend;
        if (g == 0) begin : g_first
            assign addend = {{(ACC_W-1){1'b0}}, sd_bit};
        end else begin : g_next
            assign addend = g_int[g-1].acc;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        acc <= '0;
            else if (flush)    acc <= '0;
            else if (sd_valid) acc <= acc + addend;
        end
    end

    // comb chain at the decimated rate
    logic [ACC_W-1:0] dly0_q, dly1_q, dly2_q;
    logic [ACC_W-1:0] c1, c2, c3, scaled;
    logic [OUT_W-1:0] sat;

    always_comb begin
        c1     = g_int[2].acc - dly0_q;
        c2     = c1 - dly1_q;
        c3     = c2 - dly2_q;
        scaled = ratio_q ? (c3 >> SH_HI) : (c3 >> SH_LO);
        sat    = (scaled > OUT_MAX) ? OUT_W'(OUT_MAX) : scaled[OUT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio_q <= 1'b0;
            cnt_q   <= '0;
            dly0_q  <= '0;
            dly1_q  <= '0;
            dly2_q  <= '0;
        end else begin
            ratio_q <= ratio_sel;
            if (flush) begin
                cnt_q  <= '0;
                dly0_q <= '0;
                dly1_q <= '0;
                dly2_q <= '0;
            end else begin
                if (sd_valid) cnt_q <= last ? '0 : cnt_q + 1'b1;
                if (strobe) begin
                    dly0_q <= g_int[2].acc;
                    dly1_q <= c1;
                    dly2_q <= c2;
                end
            end
        end
    end

    // settle state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DEC_SETTLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DEC_SETTLE: begin
                if (flush)                                        state_d = DEC_SETTLE;
                else if (strobe && settle_q == SC_W'(SETTLE_N-1)) state_d = DEC_LIVE;
            end
            DEC_LIVE: begin
                if (flush) state_d = DEC_SETTLE;
            end
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_q  <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= strobe && (state_q == DEC_LIVE);
            if (flush)                                 settle_q <= '0;
            else if (strobe && state_q == DEC_SETTLE)  settle_q <= settle_q + 1'b1;
            if (strobe) out_data <= sat;
        end
    end

    assign strobe_o = strobe;
    assign flush_o  = flush;
    assign ratio_o  = ratio_q;
    assign state_o  = state_q;

endmodule

// File: rtl/dclink_eval.sv
module dclink_eval
    import dclink_pkg::*;
#(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_valid,
    input  logic [VAL_W-1:0] sample,
    input  logic [VAL_W-1:0] offset,
    input  logic [VAL_W-1:0] trip_lvl,
    input  logic [VAL_W-1:0] chop_lvl,
    input  logic [VAL_W-1:0] low_lvl,
    output logic [VAL_W-1:0] reading,
    output logic             ov,
    output logic             uv,
    output logic             chop,
    output logic             upd_o
);

    localparam int SUM_W = VAL_W + 2;
    localparam logic [SUM_W-1:0] ZERO_PT = SUM_W'(64'd1 << (VAL_W - 2));
    localparam logic [SUM_W-1:0] VAL_MAX = SUM_W'((64'd1 << VAL_W) - 1);

    ev_state_t        state_q, state_d;
    logic [VAL_W-1:0] raw_q, corr_q, corr_d;
    logic [SUM_W-1:0] sum, diff;

    always_comb begin
        sum  = SUM_W'(raw_q) + SUM_W'(offset);
        diff = sum - ZERO_PT;
        if (sum < ZERO_PT)      corr_d = '0;
        else if (diff > VAL_MAX) corr_d = VAL_W'(VAL_MAX);
        else                     corr_d = diff[VAL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EV_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_WAIT:    if (sample_valid) state_d = EV_CORRECT;
            EV_CORRECT: state_d = EV_DECIDE;
            EV_DECIDE:  state_d = EV_WAIT;
            default:    state_d = EV_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q   <= '0;
            corr_q  <= '0;
            reading <= '0;
            ov      <= 1'b0;
            uv      <= 1'b0;
            chop    <= 1'b0;
        end else begin
            unique case (state_q)
                EV_WAIT:    if (sample_valid) raw_q <= sample;
                EV_CORRECT: corr_q <= corr_d;
                EV_DECIDE: begin
                    reading <= corr_q;
                    ov      <= corr_q > trip_lvl;
                    chop    <= corr_q > chop_lvl;
                    uv      <= corr_q < low_lvl;
                end
                default: ;
            endcase
        end
    end

    assign upd_o = (state_q == EV_DECIDE);

endmodule

// File: rtl/dclink_regs.sv
module dclink_regs
    import dclink_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 32,
    parameter int VAL_W   = 16,
    parameter int SPARE_N = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [VAL_W-1:0]  reading,
    input  logic              ov,
    input  logic              uv,
    input  logic              chop,
    output logic              ratio_sel,
    output logic [VAL_W-1:0]  offset,
    output logic [VAL_W-1:0]  trip_lvl,
    output logic [VAL_W-1:0]  chop_lvl,
    output logic [VAL_W-1:0]  low_lvl
);

    logic [VAL_W-1:0] spare_q [SPARE_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio_sel <= 1'b0;
            offset    <= '0;
            trip_lvl  <= '0;
            chop_lvl  <= '0;
            low_lvl   <= '0;
            for (int i = 0; i < SPARE_N; i++) spare_q[i] <= '0;
        end else if (wr) begin
            case (addr)
                A_CTRL:   ratio_sel <= wdata[0];
                A_OFFSET: offset    <= wdata[VAL_W-1:0];
                A_TRIP:   trip_lvl  <= wdata[VAL_W-1:0];
                A_CHOP:   chop_lvl  <= wdata[VAL_W-1:0];
                A_LOW:    low_lvl   <= wdata[VAL_W-1:0];
                A_SPARE0: spare_q[0] <= wdata[VAL_W-1:0];
                A_SPARE1: spare_q[1] <= wdata[VAL_W-1:0];
                A_SPARE2: spare_q[2] <= wdata[VAL_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:    rdata = DATA_W'(ratio_sel);
            A_OFFSET:  rdata = DATA_W'(offset);
            A_TRIP:    rdata = DATA_W'(trip_lvl);
            A_CHOP:    rdata = DATA_W'(chop_lvl);
            A_LOW:     rdata = DATA_W'(low_lvl);
            A_READING: rdata = DATA_W'(reading);
            A_FLAGS:   rdata = DATA_W'({chop, uv, ov});
            A_SPARE0:  rdata = DATA_W'(spare_q[0]);
            A_SPARE1:  rdata = DATA_W'(spare_q[1]);
            A_SPARE2:  rdata = DATA_W'(spare_q[2]);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/dclink_monitor.sv
module dclink_monitor
    import dclink_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32,
    parameter int VAL_W    = 16,
    parameter int LOG_R_LO = 6,
    parameter int LOG_R_HI = 7,
    parameter int SETTLE_N = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sd_valid,
    input  logic              sd_bit,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              ov_o,
    output logic              uv_o,
    output logic              chop_o
);

    logic             ratio_sel;
    logic [VAL_W-1:0] offset, trip_lvl, chop_lvl, low_lvl;
    logic             live_valid;
    logic [VAL_W-1:0] filt;
    logic             dec_strobe, dec_flush, dec_ratio;
    dec_state_t       dec_state;
    logic [VAL_W-1:0] reading;
    logic             eval_upd;

    dclink_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VAL_W(VAL_W), .SPARE_N(3)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
        .wdata(reg_wdata), .rdata(reg_rdata), .reading(reading),
        .ov(ov_o), .uv(uv_o), .chop(chop_o), .ratio_sel(ratio_sel),
        .offset(offset), .trip_lvl(trip_lvl), .chop_lvl(chop_lvl),
        .low_lvl(low_lvl)
    );

    dclink_sinc3 #(
        .LOG_R_LO(LOG_R_LO), .LOG_R_HI(LOG_R_HI), .OUT_W(VAL_W), .SETTLE_N(SETTLE_N)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .sd_valid(sd_valid), .sd_bit(sd_bit),
        .ratio_sel(ratio_sel), .out_valid(live_valid), .out_data(filt),
        .strobe_o(dec_strobe), .flush_o(dec_flush), .ratio_o(dec_ratio),
        .state_o(dec_state)
    );

    dclink_eval #(
        .VAL_W(VAL_W)
    ) u_eval (
        .clk(clk), .rst_n(rst_n), .sample_valid(live_valid), .sample(filt),
        .offset(offset), .trip_lvl(trip_lvl), .chop_lvl(chop_lvl),
        .low_lvl(low_lvl), .reading(reading), .ov(ov_o), .uv(uv_o),
        .chop(chop_o), .upd_o(eval_upd)
    );

endmodule

// File: rtl/dclink_monitor_chk.sv
module dclink_monitor_chk
    import dclink_pkg::*;
#(
    parameter int LOG_R_LO = 6,
    parameter int LOG_R_HI = 7,
    parameter int VAL_W    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sd_valid,
    input logic             dec_strobe,
    input logic             dec_flush,
    input logic             dec_ratio,
    input dec_state_t       dec_state,
    input logic             live_valid,
    input logic             eval_upd,
    input logic [VAL_W-1:0] reading,
    input logic             ov_o,
    input logic             uv_o,
    input logic             chop_o
);

    localparam int CW = LOG_R_HI + 1;
    logic [CW-1:0] seen_q;
    logic [CW-1:0] period;

    assign period = dec_ratio ? CW'(64'd1 << LOG_R_HI) : CW'(64'd1 << LOG_R_LO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          seen_q <= '0;
        else if (dec_flush)  seen_q <= '0;
        else if (dec_strobe) seen_q <= '0;
        else if (sd_valid)   seen_q <= seen_q + 1'b1;
    end

    // R1: one decimated strobe per selected number of valid bits
    p_strobe_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dec_strobe |-> (seen_q + 1'b1 == period));

    // R1: a ratio change sends the filter back to settling
    p_flush_settle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dec_flush |=> (dec_state == DEC_SETTLE));

    // R7: no sample reaches the evaluator while settling
    p_settle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_state == DEC_SETTLE) |-> !live_valid);

    // R7: outputs hold between evaluator updates
    p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_upd |=> ($stable(ov_o) && $stable(uv_o) && $stable(chop_o) && $stable(reading)));

    // R10: reset clears pins and reading
    always_comb begin
        if (!rst_n) begin
            p_reset_clear_r10: assert (!ov_o && !uv_o && !chop_o && reading == '0);
        end
    end

endmodule

bind dclink_monitor dclink_monitor_chk #(
    .LOG_R_LO(LOG_R_LO), .LOG_R_HI(LOG_R_HI), .VAL_W(VAL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sd_valid(sd_valid), .dec_strobe(dec_strobe),
    .dec_flush(dec_flush), .dec_ratio(dec_ratio), .dec_state(dec_state),
    .live_valid(live_valid), .eval_upd(eval_upd), .reading(reading),
    .ov_o(ov_o), .uv_o(uv_o), .chop_o(chop_o)
);

// File: tb/dclink_monitor_tb_top.sv
module dclink_monitor_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sd_valid = 1'b0;
    logic        sd_bit = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ov_o, uv_o, chop_o;

    int n_chk = 0;
    int n_err = 0;
    int pat_k = 32;
    int cur_m = 64;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dclink_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .sd_valid(sd_valid), .sd_bit(sd_bit),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ov_o(ov_o), .uv_o(uv_o), .chop_o(chop_o)
    );

    function automatic int exp_filt(int k);
        return (k * 1024 > 65535) ? 65535 : k * 1024;
    endfunction

    function automatic int exp_corr(int f, int off);
        int s = f + off - 16384;
        if (s < 0) s = 0;
        if (s > 65535) s = 65535;
        return s;
    endfunction

    function automatic int clamp16(int v);
        return (v < 0) ? 0 : ((v > 65535) ? 65535 : v);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output int d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic check_state(input string tag, input int corr, input int trip,
                               input int chp, input int low);
        int v;
        int eo = (corr > trip) ? 1 : 0;
        int ec = (corr > chp)  ? 1 : 0;
        int eu = (corr < low)  ? 1 : 0;
        rd(6'h14, v);
        chk({tag, " R8 R3 reading"}, v, corr);
        rd(6'h18, v);
        chk({tag, " R4 R5 R6 flags"}, v, (ec << 2) | (eu << 1) | eo);
        chk({tag, " R4 ov pin"}, int'(ov_o), eo);
        chk({tag, " R5 chop pin"}, int'(chop_o), ec);
        chk({tag, " R6 uv pin"}, int'(uv_o), eu);
    endtask

    task automatic set_levels(input int trip, input int chp, input int low);
        wr(6'h08, 32'(trip));
        wr(6'h0C, 32'(chp));
        wr(6'h10, 32'(low));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        int v, off, trip, chp, low, corr, rate, mode;
        void'($urandom(32'd20240611));
        fork
            begin
                int ph = 0;
                forever begin
                    @(negedge clk);
                    sd_valid = 1'b1;
                    sd_bit   = (ph < pat_k);
                    ph       = (ph + 1) % 64;
                end
            end
        join_none

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        rd(6'h14, v);  chk("R10 reading", v, 0);
        rd(6'h18, v);  chk("R10 flags", v, 0);
        rd(6'h00, v);  chk("R10 ctrl", v, 0);
        rd(6'h04, v);  chk("R10 offset", v, 0);
        chk("R10 pins", int'({ov_o, uv_o, chop_o}), 0);

        // R7 settle window: three samples at 64 bits are discarded
        repeat (190) @(negedge clk);
        rd(6'h14, v);  chk("R7 held during settle", v, 0);
        chk("R7 ov held during settle", int'(ov_o), 0);
        repeat (110) @(negedge clk);
        // R2/R3: k=32 gives 32768, offset 0 -> 16384; zero levels
        check_state("R7 first live", 16384, 0, 0, 0);

        // R4 R5 R6 strict compares at equality
        set_levels(16384, 16384, 16384);
        repeat (5 * 64) @(negedge clk);
        check_state("R4 R5 R6 equal", 16384, 16384, 16384, 16384);

        set_levels(65535, 65535, 65535);
        repeat (5 * 64) @(negedge clk);
        check_state("R6 under", 16384, 65535, 65535, 65535);

        // R3 low saturation
        pat_k = 0;
        repeat (5 * 64) @(negedge clk);
        check_state("R3 low sat", 0, 65535, 65535, 65535);

        // R2 full scale caps, R3 high saturation
        pat_k = 64;
        wr(6'h04, 32'd16384);
        set_levels(100, 70000 - 65536, 0);
        repeat (5 * 64) @(negedge clk);
        check_state("R2 full scale", 65535, 100, 4464, 0);
        wr(6'h04, 32'd65535);
        repeat (5 * 64) @(negedge clk);
        check_state("R3 high sat", 65535, 100, 4464, 0);

        // R9 spare registers, ignored writes, unmapped, reserved bits
        wr(6'h1C, 32'hFFFF_1234);
        wr(6'h20, 32'h0000_ABCD);
        wr(6'h24, 32'h0001_0005);
        wr(6'h14, 32'h0000_0007);
        wr(6'h18, 32'h0000_0000);
        rd(6'h1C, v);  chk("R9 spare0", v, 32'h1234);
        rd(6'h20, v);  chk("R9 spare1", v, 32'hABCD);
        rd(6'h24, v);  chk("R9 spare2", v, 32'h0005);
        rd(6'h3C, v);  chk("R9 unmapped", v, 0);
        repeat (3 * 64) @(negedge clk);
        check_state("R9 no effect", 65535, 100, 4464, 0);

        // R1 switch to ratio 128, reserved control bits read 0
        wr(6'h00, 32'hFFFF_FFFF);
        rd(6'h00, v);  chk("R1 ctrl readback", v, 1);
        cur_m = 128;
        pat_k = 20;
        wr(6'h04, 32'd16384);
        set_levels(20000, 20480, 20481);
        repeat (5 * 128) @(negedge clk);
        check_state("R1 ratio 128", 20480, 20000, 20480, 20481);

        // constrained random sweep
        for (int it = 0; it < 40; it++) begin
            rate  = int'($urandom % 2);
            pat_k = int'($urandom % 65);
            mode  = int'($urandom % 4);
            off   = (mode == 0) ? 0 : (mode == 1) ? 65535
                  : 16384 + int'($urandom % 16384) - 8192;
            corr  = exp_corr(exp_filt(pat_k), off);
            trip  = ($urandom % 2) ? int'($urandom % 65536) : clamp16(corr + int'($urandom % 3) - 1);
            chp   = ($urandom % 2) ? int'($urandom % 65536) : clamp16(corr + int'($urandom % 3) - 1);
            low   = ($urandom % 2) ? int'($urandom % 65536) : clamp16(corr + int'($urandom % 3) - 1);
            wr(6'h00, 32'(rate));
            cur_m = rate ? 128 : 64;
            wr(6'h04, 32'(off));
            set_levels(trip, chp, low);
            repeat (5 * cur_m + 20) @(negedge clk);
            check_state($sformatf("R1 R2 R3 rnd%0d", it), corr, trip, chp, low);
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule